// File: doc/BRIEF.md
# Debug-to-System-Bus Single-Transfer Bridge

This block sits behind a serial debug front end that runs on the test clock (TCK). The front end pulses a strobe with an address, a read/write flag, an access size and write data, and the block performs that one access as a classic single-transfer Wishbone master on a separate bus clock. Read data, a ready flag and a sticky error flag come back in the TCK domain. A request crosses to the bus clock as a toggle, and the completion returns the same way. Both toggles pass through two-flop synchronizers. Address, size and write data are held in TCK-domain registers that do not change while a request is pending, so the bus side can use them directly.

The TCK side is a two-state machine. READY goes to BUSY on an accepted strobe. BUSY goes back to READY when the synchronized completion toggle changes, and at that point it latches the read data and merges the error result. The bus side has three states. IDLE goes to ACCESS when the synchronized request toggle changes, and this raises cycle and strobe. ACCESS goes to RETIRE on acknowledge or error, and this drops cycle and strobe and latches the aligned read data. RETIRE goes back to IDLE and flips the completion toggle. Narrow accesses are steered onto the addressed byte lanes, with byte selects derived from the size and the two low address bits.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After reset, ready_o is 1, err_o is 0, and bus_cyc_o and bus_stb_o are 0.
- R2: A strobe sampled on a rising TCK edge while ready_o is 1 captures the request, and ready_o reads 0 from that edge on. A strobe while ready_o is 0 is ignored: it starts no bus access and alters no captured field.
- R3: During the resulting bus access, bus_cyc_o and bus_stb_o are both 1. bus_adr_o equals the captured address, and bus_we_o is the inverse of rd_wrn_i (rd_wrn_i = 1 means read, 0 means write).
- R4: Cycle and strobe stay at 1 until a bus clock edge that samples acknowledge or error, and they are 0 after that edge.
- R5: Byte lane k covers data bits 8k+7:8k. When size_i is 1, bus_sel_o has the single bit addr[1:0] set. When size_i is 2, bus_sel_o is 4'b0011 if addr[1] is 0 and 4'b1100 if it is 1. Any other size (4 in normal use) gives 4'b1111.
- R6: Write data is steered as follows. A byte is taken from wdata_i[31:24] and placed on lane addr[1:0]. A halfword is taken from wdata_i[31:16] and placed on bits 15:0 or 31:16 according to addr[1]. A word is passed unchanged. Unaddressed lanes are 0.
- R7: Read data is steered as follows. A byte on lane addr[1:0] appears on rdata_o[7:0], and a halfword from the half selected by addr[1] appears on rdata_o[15:0]. Upper bits are 0, and a word is passed unchanged.
- R8: ready_o returns to 1 after the bus access has completed, and rdata_o then holds that access's read data.
- R9: An error response completes the access and sets err_o. err_o then stays 1 through later successful accesses until rst_i is asserted.
- R10: bus_cti_o is 3'b000, bus_bte_o is 2'b00 and bus_cab_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Debug test clock |
| rst_i | input | 1 | Asynchronous reset, active high, both domains; also clears the error flag |
| strobe_i | input | 1 | Request strobe, TCK domain |
| rd_wrn_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 3 | Access size in bytes: 1, 2 or 4 |
| addr_i | input | 32 | Request address |
| wdata_i | input | 32 | Write data, narrow data left-justified |
| ready_o | output | 1 | 1 when idle and the last result is available |
| err_o | output | 1 | Sticky bus error flag |
| rdata_o | output | 32 | Read data, right-justified |
| bus_clk_i | input | 1 | Bus clock |
| bus_adr_o | output | 32 | Bus address |
| bus_dat_o | output | 32 | Bus write data |
| bus_dat_i | input | 32 | Bus read data |
| bus_cyc_o | output | 1 | Bus cycle |
| bus_stb_o | output | 1 | Bus strobe |
| bus_sel_o | output | 4 | Byte lane selects |
| bus_we_o | output | 1 | Write enable |
| bus_ack_i | input | 1 | Acknowledge |
| bus_cab_o | output | 1 | Classic burst flag, held low |
| bus_err_i | input | 1 | Error response |
| bus_cti_o | output | 3 | Cycle type, classic |
| bus_bte_o | output | 2 | Burst type |

## Verification
The assertions assume three things about the inputs. The two clocks are unrelated but both free-running. rst_i is asserted in both domains at once. The bus slave never answers unless cycle and strobe are high. The bench meets these conditions. Its slave model raises acknowledge or error only while it sees an open cycle, and it drops the response at the very next bus clock. Strobes are driven only on falling TCK edges, and reset is released between edges of both clocks. The half and word accesses it issues are naturally aligned, so the lane rules are exercised only where they are defined.

// File: rtl/dbgbr_pkg.sv
package dbgbr_pkg;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_HALF = 3'd2;

    typedef enum logic {
        T_READY = 1'b0,
        T_BUSY  = 1'b1
    } tck_state_e;

    typedef enum logic [1:0] {
        B_IDLE   = 2'd0,
        B_ACCESS = 2'd1,
        B_RETIRE = 2'd2
    } bus_state_e;

endpackage

// File: rtl/dbgbr_sync.sv
module dbgbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbgbr_lanes.sv
module dbgbr_lanes
    import dbgbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]               size_i,
    input  logic [$clog2(DATA_W/8)-1:0] ofs_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [DATA_W-1:0]        bus_rdata_i,
    output logic [DATA_W/8-1:0]      sel_o,
    output logic [DATA_W-1:0]        bus_wdata_o,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic              is_byte;
    logic              is_half;
    logic [OFS_W-2:0]  half_idx;
    logic [DATA_W-1:0] rd_byte_sh;
    logic [DATA_W-1:0] rd_half_sh;

    assign is_byte  = (size_i == SZ_BYTE);
    assign is_half  = (size_i == SZ_HALF);
    assign half_idx = ofs_i[OFS_W-1:1];

    // one select bit per byte lane
    for (genvar k = 0; k < LANES; k++) begin : g_sel
        always_comb begin
            if (is_byte) begin
                sel_o[k] = (ofs_i == OFS_W'(k));
            end else if (is_half) begin
                sel_o[k] = (half_idx == (OFS_W-1)'(k / 2));
            end else begin
                sel_o[k] = 1'b1;
            end
        end
    end

    // left-justified narrow write data moved onto the addressed lanes
    always_comb begin
        if (is_byte) begin
            bus_wdata_o = DATA_W'(wdata_i[DATA_W-1 -: 8]) << {ofs_i, 3'b000};
        end else if (is_half) begin
            bus_wdata_o = DATA_W'(wdata_i[DATA_W-1 -: 16]) << {half_idx, 4'b0000};
        end else begin
            bus_wdata_o = wdata_i;
        end
    end

    // addressed read lanes moved down to bit 0
    assign rd_byte_sh = bus_rdata_i >> {ofs_i, 3'b000};
    assign rd_half_sh = bus_rdata_i >> {half_idx, 4'b0000};

    always_comb begin
        if (is_byte) begin
            rdata_o = DATA_W'(rd_byte_sh[7:0]);
        end else if (is_half) begin
            rdata_o = DATA_W'(rd_half_sh[15:0]);
        end else begin
            rdata_o = bus_rdata_i;
        end
    end
endmodule

// File: rtl/dbgbr_tck_side.sv
module dbgbr_tck_side
    import dbgbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tck_i,
    input  logic              rst_i,
    input  logic              strobe_i,
    input  logic              rd_wrn_i,
    input  logic [2:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_tgl_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_err_i,
    output logic              req_tgl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic [2:0]        size_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              ready_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o
);
    tck_state_e        state_q;
    tck_state_e        state_d;
    logic              done_sync;
    logic              done_seen_q;
    logic              done_evt;
    logic              accept;
    logic              req_tgl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [2:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    dbgbr_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk_i (tck_i),
        .rst_i (rst_i),
        .d_i   (done_tgl_i),
        .q_o   (done_sync)
    );

    assign done_evt = (done_sync != done_seen_q);
    assign accept   = (state_q == T_READY) && strobe_i;

    always_ff @(posedge tck_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= T_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_READY: if (strobe_i) state_d = T_BUSY;
            T_BUSY:  if (done_evt) state_d = T_READY;
            default: state_d = T_READY;
        endcase
    end

    always_ff @(posedge tck_i or posedge rst_i) begin
        if (rst_i) begin
            req_tgl_q   <= 1'b0;
            done_seen_q <= 1'b0;
            addr_q      <= '0;
            rd_q        <= 1'b0;
            size_q      <= 3'd0;
            wdata_q     <= '0;
            err_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                req_tgl_q <= ~req_tgl_q;
                addr_q    <= addr_i;
                rd_q      <= rd_wrn_i;
                size_q    <= size_i;
                wdata_q   <= wdata_i;
            end
            if ((state_q == T_BUSY) && done_evt) begin
                done_seen_q <= done_sync;
                rdata_q     <= bus_rdata_i;
                if (bus_err_i) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign req_tgl_o = req_tgl_q;
    assign addr_o    = addr_q;
    assign rd_o      = rd_q;
    assign size_o    = size_q;
    assign wdata_o   = wdata_q;
    assign ready_o   = (state_q == T_READY);
    assign err_o     = err_q;
    assign rdata_o   = rdata_q;

    // R2
    strobe_accept_chk: assert property (@(posedge tck_i) disable iff (rst_i)
        (ready_o && strobe_i) |=> !ready_o);

    // R2
    busy_stable_chk: assert property (@(posedge tck_i) disable iff (rst_i)
        (state_q == T_BUSY) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(size_q)));

    // R9
    err_sticky_chk: assert property (@(posedge tck_i) disable iff (rst_i)
        err_q |=> err_q);
endmodule

// File: rtl/dbgbr_bus_side.sv
module dbgbr_bus_side
    import dbgbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_tgl_i,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic [DATA_W-1:0] aligned_rdata_i,
    output logic              cyc_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              done_tgl_o
);
    bus_state_e        state_q;
    bus_state_e        state_d;
    logic              req_sync;
    logic              req_seen_q;
    logic              req_evt;
    logic              resp;
    logic              cyc_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              done_q;

    dbgbr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (req_tgl_i),
        .q_o   (req_sync)
    );

    assign req_evt = (req_sync != req_seen_q);
    assign resp    = ack_i || err_i;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= B_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE:   if (req_evt) state_d = B_ACCESS;
            B_ACCESS: if (resp)    state_d = B_RETIRE;
            B_RETIRE: state_d = B_IDLE;
            default:  state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            req_seen_q <= 1'b0;
            cyc_q      <= 1'b0;
            rdata_q    <= '0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            unique case (state_q)
                B_IDLE: begin
                    if (req_evt) begin
                        req_seen_q <= req_sync;
                        cyc_q      <= 1'b1;
                    end
                end
                B_ACCESS: begin
                    if (resp) begin
                        cyc_q   <= 1'b0;
                        rdata_q <= aligned_rdata_i;
                        err_q   <= err_i;
                    end
                end
                B_RETIRE: begin
                    done_q <= ~done_q;
                end
                default: begin
                    cyc_q <= 1'b0;
                end
            endcase
        end
    end

    assign cyc_o      = cyc_q;
    assign rdata_o    = rdata_q;
    assign err_o      = err_q;
    assign done_tgl_o = done_q;

    // R4
    cyc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_q && !ack_i && !err_i) |=> cyc_q);

    // R4
    cyc_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_q && resp) |=> !cyc_q);
endmodule

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge
    import dbgbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                tck_i,
    input  logic                rst_i,
    input  logic                strobe_i,
    input  logic                rd_wrn_i,
    input  logic [2:0]          size_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                ready_o,
    output logic                err_o,
    output logic [DATA_W-1:0]   rdata_o,
    input  logic                bus_clk_i,
    output logic [ADDR_W-1:0]   bus_adr_o,
    output logic [DATA_W-1:0]   bus_dat_o,
    input  logic [DATA_W-1:0]   bus_dat_i,
    output logic                bus_cyc_o,
    output logic                bus_stb_o,
    output logic [DATA_W/8-1:0] bus_sel_o,
    output logic                bus_we_o,
    input  logic                bus_ack_i,
    output logic                bus_cab_o,
    input  logic                bus_err_i,
    output logic [2:0]          bus_cti_o,
    output logic [1:0]          bus_bte_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic              req_tgl;
    logic              done_tgl;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [2:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] aligned_rdata;
    logic [DATA_W-1:0] held_rdata;
    logic              held_err;
    logic              cyc;

    dbgbr_tck_side #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tck (
        .tck_i       (tck_i),
        .rst_i       (rst_i),
        .strobe_i    (strobe_i),
        .rd_wrn_i    (rd_wrn_i),
        .size_i      (size_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .done_tgl_i  (done_tgl),
        .bus_rdata_i (held_rdata),
        .bus_err_i   (held_err),
        .req_tgl_o   (req_tgl),
        .addr_o      (addr_q),
        .rd_o        (rd_q),
        .size_o      (size_q),
        .wdata_o     (wdata_q),
        .ready_o     (ready_o),
        .err_o       (err_o),
        .rdata_o     (rdata_o)
    );

    dbgbr_lanes #(.DATA_W(DATA_W)) u_lanes (
        .size_i      (size_q),
        .ofs_i       (addr_q[OFS_W-1:0]),
        .wdata_i     (wdata_q),
        .bus_rdata_i (bus_dat_i),
        .sel_o       (bus_sel_o),
        .bus_wdata_o (bus_dat_o),
        .rdata_o     (aligned_rdata)
    );

    dbgbr_bus_side #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bus (
        .clk_i           (bus_clk_i),
        .rst_i           (rst_i),
        .req_tgl_i       (req_tgl),
        .ack_i           (bus_ack_i),
        .err_i           (bus_err_i),
        .aligned_rdata_i (aligned_rdata),
        .cyc_o           (cyc),
        .rdata_o         (held_rdata),
        .err_o           (held_err),
        .done_tgl_o      (done_tgl)
    );

    assign bus_adr_o = addr_q;
    assign bus_we_o  = ~rd_q;
    assign bus_cyc_o = cyc;
    assign bus_stb_o = cyc;
    assign bus_cti_o = 3'b000;
    assign bus_bte_o = 2'b00;
    assign bus_cab_o = 1'b0;

    // R5
    byte_sel_single_chk: assert property (@(posedge bus_clk_i) disable iff (rst_i)
        (bus_cyc_o && size_q == SZ_BYTE) |-> ($countones(bus_sel_o) == 1));

    // R5
    half_sel_pair_chk: assert property (@(posedge bus_clk_i) disable iff (rst_i)
        (bus_cyc_o && size_q == SZ_HALF) |-> ($countones(bus_sel_o) == 2));
endmodule

// File: tb/dbg_bus_bridge_tb.sv
module dbg_bus_bridge_tb_top;
    logic        bclk = 1'b0;
    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        rd_wrn = 1'b0;
    logic [2:0]  size = 3'd4;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ready;
    logic        err;
    logic [31:0] rdata;
    logic [31:0] bus_adr;
    logic [31:0] bus_dat_o;
    logic [31:0] bus_dat_i = '0;
    logic        bus_cyc;
    logic        bus_stb;
    logic [3:0]  bus_sel;
    logic        bus_we;
    logic        bus_ack = 1'b0;
    logic        bus_cab;
    logic        bus_err = 1'b0;
    logic [2:0]  bus_cti;
    logic [1:0]  bus_bte;

    int n_chk = 0;
    int n_fail = 0;
    int n_txn = 0;
    int exp_txn = 0;

    logic [31:0] exp_adr = '0;
    logic        exp_we = 1'b0;
    logic [3:0]  exp_sel = '0;
    logic [31:0] exp_dat = '0;
    logic        exp_err = 1'b0;
    int          sl_delay = 0;
    logic        sl_err = 1'b0;

    always #2 bclk = ~bclk;
    always #11 tck = ~tck;

    dbg_bus_bridge dut_i (
        .tck_i (tck), .rst_i (rst), .strobe_i (strobe), .rd_wrn_i (rd_wrn),
        .size_i (size), .addr_i (addr), .wdata_i (wdata),
        .ready_o (ready), .err_o (err), .rdata_o (rdata),
        .bus_clk_i (bclk), .bus_adr_o (bus_adr), .bus_dat_o (bus_dat_o),
        .bus_dat_i (bus_dat_i), .bus_cyc_o (bus_cyc), .bus_stb_o (bus_stb),
        .bus_sel_o (bus_sel), .bus_we_o (bus_we), .bus_ack_i (bus_ack),
        .bus_cab_o (bus_cab), .bus_err_i (bus_err), .bus_cti_o (bus_cti),
        .bus_bte_o (bus_bte)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // expected values straight from the lane rules of R5, R6, R7
    function automatic logic [3:0] sel_of(input logic [2:0] sz, input logic [1:0] a);
        if (sz == 3'd1) return 4'b0001 << a;
        if (sz == 3'd2) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] wdat_of(input logic [2:0] sz, input logic [1:0] a, input logic [31:0] w);
        if (sz == 3'd1) return {24'd0, w[31:24]} << (8 * a);
        if (sz == 3'd2) return {16'd0, w[31:16]} << (16 * a[1]);
        return w;
    endfunction

    function automatic logic [31:0] rdat_of(input logic [2:0] sz, input logic [1:0] a, input logic [31:0] d);
        logic [31:0] t;
        if (sz == 3'd1) begin
            t = d >> (8 * a);
            return {24'd0, t[7:0]};
        end
        if (sz == 3'd2) begin
            t = d >> (16 * a[1]);
            return {16'd0, t[15:0]};
        end
        return d;
    endfunction

    // bus slave model: answers only an open cycle, drops the answer next clock
    initial begin
        int waited = 0;
        forever begin
            @(negedge bclk);
            if (bus_ack || bus_err) begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
                // R4 released one bus clock after the response
                chk(bus_cyc == 1'b0, "R4 cyc after response", {31'd0, bus_cyc}, 32'd0);
            end else if (!rst && bus_cyc) begin
                if (waited < sl_delay) begin
                    waited++;
                end else begin
                    waited = 0;
                    n_txn++;
                    if (sl_err) bus_err = 1'b1;
                    else bus_ack = 1'b1;
                end
            end
        end
    end

    // per-clock comparison of the master outputs against the reference
    initial begin
        forever begin
            @(negedge bclk);
            // R10
            chk({bus_cti, bus_bte, bus_cab} == 6'd0, "R10 qualifiers", {26'd0, bus_cti, bus_bte, bus_cab}, 32'd0);
            if (!rst && bus_cyc) begin
                chk(bus_stb == 1'b1, "R3 stb", {31'd0, bus_stb}, 32'd1);
                chk(bus_adr == exp_adr, "R3 adr", bus_adr, exp_adr);
                chk(bus_we == exp_we, "R3 we", {31'd0, bus_we}, {31'd0, exp_we});
                chk(bus_sel == exp_sel, "R5 sel", {28'd0, bus_sel}, {28'd0, exp_sel});
                if (exp_we) chk(bus_dat_o == exp_dat, "R6 wdata", bus_dat_o, exp_dat);
            end
        end
    end

    task automatic access(input logic [31:0] a, input logic rd, input logic [2:0] sz,
                          input logic [31:0] w, input logic [31:0] d, input logic er,
                          input int dly, input bit poke);
        @(negedge tck);
        exp_adr = a;
        exp_we = ~rd;
        exp_sel = sel_of(sz, a[1:0]);
        exp_dat = wdat_of(sz, a[1:0], w);
        bus_dat_i = d;
        sl_err = er;
        sl_delay = dly;
        addr = a; rd_wrn = rd; size = sz; wdata = w; strobe = 1'b1;
        exp_txn++;
        @(negedge tck);
        strobe = 1'b0;
        // R2
        chk(ready == 1'b0, "R2 ready drops", {31'd0, ready}, 32'd0);
        if (poke) begin
            addr = a ^ 32'h40; wdata = ~w; rd_wrn = ~rd; strobe = 1'b1;
            @(negedge tck);
            strobe = 1'b0;
            chk(ready == 1'b0, "R2 busy strobe", {31'd0, ready}, 32'd0);
        end
        for (int i = 0; i < 200 && !ready; i++) @(negedge tck);
        // R8
        chk(ready == 1'b1, "R8 ready returns", {31'd0, ready}, 32'd1);
        if (er) exp_err = 1'b1;
        // R9
        chk(err == exp_err, "R9 error flag", {31'd0, err}, {31'd0, exp_err});
        if (rd && !er) chk(rdata == rdat_of(sz, a[1:0], d), "R7 rdata", rdata, rdat_of(sz, a[1:0], d));
        if (poke) begin
            repeat (4) @(negedge tck);
            chk(bus_cyc == 1'b0, "R2 ignored strobe no cycle", {31'd0, bus_cyc}, 32'd0);
        end
        chk(n_txn == exp_txn, "R2 transaction count", n_txn, exp_txn);
    endtask

    task automatic pulse_reset();
        @(negedge tck);
        #3 rst = 1'b1;
        #1;
        // R1
        chk(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
        chk(err == 1'b0, "R1 err", {31'd0, err}, 32'd0);
        chk({bus_cyc, bus_stb} == 2'b00, "R1 cyc stb", {30'd0, bus_cyc, bus_stb}, 32'd0);
        exp_err = 1'b0;
        @(negedge tck);
        #3 rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge bclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        chk(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
        chk(err == 1'b0, "R1 err", {31'd0, err}, 32'd0);
        chk(bus_cyc == 1'b0, "R1 cyc", {31'd0, bus_cyc}, 32'd0);
        repeat (2) @(negedge tck);
        #3 rst = 1'b0;

        access(32'h0000_0100, 1'b0, 3'd4, 32'hDEAD_BEEF, 32'h0, 1'b0, 2, 1'b0);
        access(32'h0000_0104, 1'b1, 3'd4, 32'h0, 32'h1234_5678, 1'b0, 0, 1'b0);
        for (int k = 0; k < 4; k++)
            access(32'h0000_0200 + k, 1'b0, 3'd1, {8'hA0 + 8'(k), 24'hFFFFFF}, 32'h0, 1'b0, 1, 1'b0);
        for (int k = 0; k < 4; k++)
            access(32'h0000_0300 + k, 1'b1, 3'd1, 32'h0, 32'h4433_2211, 1'b0, k, 1'b0);
        access(32'h0000_0400, 1'b0, 3'd2, 32'hBEEF_1111, 32'h0, 1'b0, 0, 1'b0);
        access(32'h0000_0402, 1'b0, 3'd2, 32'hCAFE_2222, 32'h0, 1'b0, 3, 1'b0);
        access(32'h0000_0500, 1'b1, 3'd2, 32'h0, 32'h8765_4321, 1'b0, 1, 1'b0);
        access(32'h0000_0502, 1'b1, 3'd2, 32'h0, 32'h8765_4321, 1'b0, 0, 1'b0);
        // R2 strobe while busy must be ignored
        access(32'h0000_0600, 1'b0, 3'd4, 32'h0BAD_F00D, 32'h0, 1'b0, 30, 1'b1);
        // R9 error then a good access keeps the flag
        access(32'h0000_0700, 1'b1, 3'd4, 32'h0, 32'h5555_AAAA, 1'b1, 2, 1'b0);
        access(32'h0000_0704, 1'b1, 3'd4, 32'h0, 32'h0F0F_0F0F, 1'b0, 0, 1'b0);
        access(32'h0000_0708, 1'b0, 3'd1, 32'h7700_0000, 32'h0, 1'b1, 0, 1'b0);
        // R9 only reset clears the flag
        pulse_reset();
        access(32'h0000_0800, 1'b1, 3'd4, 32'h0, 32'hC001_D00D, 1'b0, 1, 1'b0);

        repeat (4) @(negedge tck);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule